// File: doc/BRIEF.md
# Decoded Sector Buffer Writer

This block receives decoded disc sectors as a byte stream: four header bytes first, then 2048 user-data bytes, so 2052 bytes per sector. When decoding is enabled, each finished sector does three things. Its header is copied into the header register, the valid status byte is driven to its active value, and a decoder-pending flag is set. That flag can raise an interrupt if two enables allow it.

When buffer writing is also enabled, the block first steps a block pointer and a write address. Each moves on by one raw sector length, 2352 bytes, even though only 2052 bytes are stored. The header and data then go into a 16 KiB circular buffer, starting at the stepped pointer taken modulo the buffer size. Writes that run past the last location wrap to address 0.

When buffer writing is off, the sector is decoded but not consumed. In that case the source presents the same sector again. A read strobe on the valid status byte returns it to its idle value and clears the pending flag.

Top module: `sector_buf_writer`

## Requirements
- R1: If `dec_en` is 0 when the first header byte is accepted, the whole sector is accepted and dropped. There are no buffer writes and no `sect_adv` pulse, and `hdr_cur`, `stat3`, `dec_pend_n`, `blk_ptr` and `wr_addr` all keep their values.
- R2: When a decoded sector commits (on the edge that accepts its 2052nd byte), `hdr_cur` takes the four header bytes, with the first byte in bits 31:24 and the fourth in bits 7:0. `stat3` becomes 0x00 on the same edge.
- R3: A decoded sector commit drives `dec_pend_n` low (pending). While it is low, `stat3` reads 0x00.
- R4: `irq` is high exactly when `dec_pend_n` is low, `dec_irq_en` is 1 and `lvl_en` is 1. It follows these inputs within the same cycle.
- R5: A commit with writing enabled adds 2352 to both `blk_ptr` and `wr_addr`, modulo 2^16. It also pulses `sect_adv` high for exactly one cycle, in the cycle after the commit edge.
- R6: With writing enabled, byte i (0..2051, header first) is written once, to address ((`blk_ptr` before the commit) + 2352 + i) mod 16384. `buf_we`, `buf_addr` and `buf_wdata` show the write in the cycle after the byte is accepted.
- R7: With `dec_en` 1 and `wr_en` 0, a sector updates `hdr_cur`, `stat3` and `dec_pend_n` as in R2 and R3. It makes no buffer writes, leaves `blk_ptr` and `wr_addr` unchanged, and keeps `sect_adv` low, so the source repeats the sector.
- R8: A one-cycle `stat3_rd` pulse sets `stat3` to 0x80 and `dec_pend_n` to 1 from the next cycle, provided no sector commits on the same edge. Before that edge, `stat3` shows its current value.
- R9: After reset, `hdr_cur` = 0x00000001, `hdr_alt` = 0, `stat3` = 0x80, `dec_pend_n` = 1, `irq` = 0, `buf_we` = 0, `sect_adv` = 0, and `blk_ptr` = `wr_addr` = 0.
- R10: `dec_en` and `wr_en` are sampled on the first header byte and held for the rest of the sector. `in_ready` is always 1. Cycles with `in_valid` low only pause the sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sector byte present |
| in_data | input | 8 | Sector byte (header first, then data) |
| in_ready | output | 1 | Always 1: one byte taken per cycle |
| dec_en | input | 1 | Decode enable |
| wr_en | input | 1 | Buffer write request |
| dec_irq_en | input | 1 | Decoder interrupt enable |
| lvl_en | input | 1 | External interrupt level enable |
| stat3_rd | input | 1 | Read strobe for the valid status byte |
| buf_we | output | 1 | Buffer write enable |
| buf_addr | output | 14 | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| sect_adv | output | 1 | Sector consumed; source moves to the next one |
| hdr_cur | output | 32 | Header of the last decoded sector |
| hdr_alt | output | 32 | Alternate header register (zero) |
| stat3 | output | 8 | Valid status byte (0x00 valid, 0x80 idle) |
| dec_pend_n | output | 1 | Decoder pending, active low |
| irq | output | 1 | Decoder interrupt request |
| blk_ptr | output | 16 | Block pointer |
| wr_addr | output | 16 | Write address |

## Verification
The bench targets three things. It drives the one sector whose 2052 stored bytes straddle the end of the ring; a design that masked only the base and not each byte address would write the tail past 16383 or back onto the base. It checks the 16-bit rollover of the block pointer on the following sector, and a decode-only sector, which must still latch the header while leaving the pointers and the buffer untouched; a design that committed anyway would move the source to the next sector too early. It also flips `wr_en` part-way through a stalled sector; a design that reads the mode live instead of sampling it would stop writing halfway and break the pointer step.

// File: rtl/sbw_pkg.sv
// sbw_pkg: shared types and constants for the sector buffer writer.
// Assumes an 8-bit byte stream and an 8-bit valid status byte.
package sbw_pkg;
    // Sector handling mode, captured on the first header byte.
    typedef struct packed {
        logic dec;
        logic wr;
    } sbw_mode_t;

    localparam logic [7:0] STAT3_IDLE  = 8'h80;
    localparam logic [7:0] STAT3_VALID = 8'h00;
endpackage

// File: rtl/sbw_seq.sv
// sbw_seq: counts bytes inside a sector and holds the mode sampled on byte 0.
// Assumes take is asserted at most once per cycle; bytes past the last one
// start a new sector.
module sbw_seq
    import sbw_pkg::*;
#(
    parameter int SECT_N = 2052,
    localparam int CNT_W = $clog2(SECT_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             dec_en,
    input  logic             wr_en,
    output logic [CNT_W-1:0] idx,
    output sbw_mode_t        mode,
    output logic             last
);
    sbw_mode_t mode_q;
    logic      first;

    // Byte 0 uses the live controls; later bytes use the held copy.
    always_comb begin
        first = (idx == '0);
        last  = (idx == CNT_W'(SECT_N - 1));
        mode  = first ? '{dec: dec_en, wr: wr_en} : mode_q;
    end

    // Advance the byte index and capture the mode at sector start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            mode_q <= '0;
        end else if (take) begin
            idx <= last ? '0 : idx + 1'b1;
            if (first) mode_q <= mode;
        end
    end
endmodule

// File: rtl/sbw_ring_addr.sv
// sbw_ring_addr: block pointer, write address and ring address generation.
// Assumes the pointer moves only on a committed written sector, so the base
// seen by every byte of a sector is the same.
module sbw_ring_addr #(
    parameter int PTR_W   = 16,
    parameter int RING_AW = 14,
    parameter int STEP    = 2352,
    parameter int CNT_W   = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               adv,
    input  logic [CNT_W-1:0]   idx,
    output logic [PTR_W-1:0]   blk_ptr,
    output logic [PTR_W-1:0]   wr_addr,
    output logic [RING_AW-1:0] ring_addr
);
    logic [RING_AW-1:0] base_lo;

    // Target of the current byte: stepped pointer plus index, ring wrapped.
    always_comb begin
        base_lo   = blk_ptr[RING_AW-1:0] + RING_AW'(STEP);
        ring_addr = base_lo + RING_AW'(idx);
    end

    // Step both counters by one raw sector length on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_ptr <= '0;
            wr_addr <= '0;
        end else if (adv) begin
            blk_ptr <= blk_ptr + PTR_W'(STEP);
            wr_addr <= wr_addr + PTR_W'(STEP);
        end
    end
endmodule

// File: rtl/sbw_status.sv
// sbw_status: header shadow, current header, valid status byte and pending flag.
// Assumes commit only happens on the last byte, after all header bytes are
// shadowed; a commit beats a status read on the same edge.
module sbw_status
    import sbw_pkg::*;
#(
    parameter int HDR_N = 4,
    parameter int CNT_W = 12,
    localparam int HDR_W = 8 * HDR_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [CNT_W-1:0] idx,
    input  logic [7:0]       in_data,
    input  logic             commit,
    input  logic             stat3_rd,
    output logic [HDR_W-1:0] hdr_cur,
    output logic [7:0]       stat3,
    output logic             dec_pend_n
);
    logic [HDR_W-1:0] shadow;

    for (genvar k = 0; k < HDR_N; k++) begin : g_hdr
        // Hold header byte k, first byte in the top lane.
        always_ff @(posedge clk) begin
            if (!rst_n)
                shadow[8*(HDR_N-1-k) +: 8] <= '0;
            else if (cap && idx == CNT_W'(k))
                shadow[8*(HDR_N-1-k) +: 8] <= in_data;
        end
    end

    // Publish the header and flags on commit, restore them on status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_cur    <= HDR_W'(1);
            stat3      <= STAT3_IDLE;
            dec_pend_n <= 1'b1;
        end else if (commit) begin
            hdr_cur    <= shadow;
            stat3      <= STAT3_VALID;
            dec_pend_n <= 1'b0;
        end else if (stat3_rd) begin
            stat3      <= STAT3_IDLE;
            dec_pend_n <= 1'b1;
        end
    end
endmodule

// File: rtl/sector_buf_writer.sv
// sector_buf_writer: takes decoded sectors, latches headers and flags, and
// stores written sectors into a circular buffer at a 2352-byte stride.
// Assumes the source re-presents a sector when sect_adv does not pulse.
module sector_buf_writer
    import sbw_pkg::*;
#(
    parameter int PTR_W   = 16,
    parameter int RING_AW = 14,
    parameter int HDR_N   = 4,
    parameter int DATA_N  = 2048,
    parameter int STEP    = 2352,
    localparam int SECT_N = HDR_N + DATA_N,
    localparam int CNT_W  = $clog2(SECT_N),
    localparam int HDR_W  = 8 * HDR_N
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    input  logic               dec_en,
    input  logic               wr_en,
    input  logic               dec_irq_en,
    input  logic               lvl_en,
    input  logic               stat3_rd,
    output logic               buf_we,
    output logic [RING_AW-1:0] buf_addr,
    output logic [7:0]         buf_wdata,
    output logic               sect_adv,
    output logic [HDR_W-1:0]   hdr_cur,
    output logic [HDR_W-1:0]   hdr_alt,
    output logic [7:0]         stat3,
    output logic               dec_pend_n,
    output logic               irq,
    output logic [PTR_W-1:0]   blk_ptr,
    output logic [PTR_W-1:0]   wr_addr
);
    logic               take;
    logic [CNT_W-1:0]   idx;
    sbw_mode_t          mode;
    logic               last;
    logic               commit;
    logic               adv;
    logic [RING_AW-1:0] ring_addr;

    // Handshake and commit decode.
    always_comb begin
        in_ready = 1'b1;
        take     = in_valid;
        commit   = take && last && mode.dec;
        adv      = commit && mode.wr;
        irq      = !dec_pend_n && dec_irq_en && lvl_en;
        hdr_alt  = '0;
    end

    sbw_seq #(.SECT_N(SECT_N)) u_seq (
        .clk(clk), .rst_n(rst_n), .take(take), .dec_en(dec_en),
        .wr_en(wr_en), .idx(idx), .mode(mode), .last(last)
    );

    sbw_ring_addr #(.PTR_W(PTR_W), .RING_AW(RING_AW), .STEP(STEP), .CNT_W(CNT_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .adv(adv), .idx(idx),
        .blk_ptr(blk_ptr), .wr_addr(wr_addr), .ring_addr(ring_addr)
    );

    sbw_status #(.HDR_N(HDR_N), .CNT_W(CNT_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .cap(take && mode.dec), .idx(idx),
        .in_data(in_data), .commit(commit), .stat3_rd(stat3_rd),
        .hdr_cur(hdr_cur), .stat3(stat3), .dec_pend_n(dec_pend_n)
    );

    // Register the buffer write port and the sector-consumed pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we    <= 1'b0;
            buf_addr  <= '0;
            buf_wdata <= '0;
            sect_adv  <= 1'b0;
        end else begin
            buf_we    <= take && mode.dec && mode.wr;
            buf_addr  <= ring_addr;
            buf_wdata <= in_data;
            sect_adv  <= adv;
        end
    end
endmodule

// File: rtl/sbw_chk.sv
// sbw_chk: property checks for sector_buf_writer, attached by bind.
// Assumes reset is held for at least one clock before use.
module sbw_chk #(
    parameter int PTR_W = 16,
    parameter int STEP  = 2352
) (
    input logic             clk,
    input logic             rst_n,
    input logic             stat3_rd,
    input logic             commit,
    input logic             sect_adv,
    input logic             buf_we,
    input logic [7:0]       stat3,
    input logic             dec_pend_n,
    input logic [PTR_W-1:0] blk_ptr,
    input logic [PTR_W-1:0] wr_addr
);
    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sect_adv |-> blk_ptr == $past(blk_ptr) + PTR_W'(STEP));

    assert_wa_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sect_adv |-> wr_addr == $past(wr_addr) + PTR_W'(STEP));

    assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !sect_adv |-> $stable(blk_ptr));

    assert_pend_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_pend_n |-> stat3 == 8'h00);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat3_rd && !commit) |=> (stat3 == 8'h80 && dec_pend_n));

    assert_last_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sect_adv |-> buf_we);
endmodule

bind sector_buf_writer sbw_chk #(.PTR_W(PTR_W), .STEP(STEP)) u_chk (
    .clk(clk), .rst_n(rst_n), .stat3_rd(stat3_rd), .commit(commit),
    .sect_adv(sect_adv), .buf_we(buf_we), .stat3(stat3),
    .dec_pend_n(dec_pend_n), .blk_ptr(blk_ptr), .wr_addr(wr_addr)
);

// File: tb/sector_buf_writer_test.sv
`timescale 1ns/1ps
// Directed bench for sector_buf_writer: one task per scenario.
module sector_buf_writer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic        dec_en = 1'b0, wr_en = 1'b0, dec_irq_en = 1'b0, lvl_en = 1'b0;
    logic        stat3_rd = 1'b0;
    logic        buf_we;
    logic [13:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic        sect_adv;
    logic [31:0] hdr_cur, hdr_alt;
    logic [7:0]  stat3;
    logic        dec_pend_n, irq;
    logic [15:0] blk_ptr, wr_addr;

    int checks = 0, errors = 0;
    int wr_cnt = 0, wr_bad = 0, adv_cnt = 0;
    logic [15:0] exp_pt = '0;
    logic [13:0] exp_base = '0;
    logic [7:0]  exp_seed = '0;

    always #4 clk = ~clk;

    sector_buf_writer uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .dec_en(dec_en), .wr_en(wr_en),
        .dec_irq_en(dec_irq_en), .lvl_en(lvl_en), .stat3_rd(stat3_rd),
        .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .sect_adv(sect_adv), .hdr_cur(hdr_cur), .hdr_alt(hdr_alt),
        .stat3(stat3), .dec_pend_n(dec_pend_n), .irq(irq),
        .blk_ptr(blk_ptr), .wr_addr(wr_addr)
    );

    function automatic logic [7:0] pat(input logic [7:0] s, input int j);
        int v;
        v = (j < 4) ? int'(s) + j : int'(s) + j * 5;
        return v[7:0];
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Observe buffer writes against the expected address and byte stream.
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we) begin
                if (buf_addr !== exp_base + 14'(wr_cnt) || buf_wdata !== pat(exp_seed, wr_cnt))
                    wr_bad++;
                wr_cnt++;
            end
            if (sect_adv) adv_cnt++;
        end
    end

    task automatic send(input logic [7:0] seed, input int toggle_at, input int gap_every);
        exp_seed = seed;
        exp_base = 14'(exp_pt + 16'd2352);
        wr_cnt = 0; wr_bad = 0; adv_cnt = 0;
        for (int j = 0; j < 2052; j++) begin
            @(negedge clk);
            if (gap_every > 0 && j > 0 && j % gap_every == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data = pat(seed, j);
            if (j == toggle_at) wr_en = ~wr_en;
        end
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [31:0] hdr_of(input logic [7:0] s);
        return {pat(s, 0), pat(s, 1), pat(s, 2), pat(s, 3)};
    endfunction

    task automatic t_reset;
        chk("R9 hdr_cur", hdr_cur, 32'h0000_0001);
        chk("R9 hdr_alt", hdr_alt, 0);
        chk("R9 stat3", stat3, 8'h80);
        chk("R9 pend_n", dec_pend_n, 1);
        chk("R9 irq/we/adv", {irq, buf_we, sect_adv}, 0);
        chk("R9 ptrs", {blk_ptr, wr_addr}, 0);
    endtask

    task automatic t_ignored;
        dec_en = 1'b0; wr_en = 1'b1;
        send(8'h11, -1, 0);
        chk("R1 writes", wr_cnt, 0);
        chk("R1 adv", adv_cnt, 0);
        chk("R1 hdr", hdr_cur, 32'h0000_0001);
        chk("R1 stat3/pend", {stat3, dec_pend_n}, {8'h80, 1'b1});
        chk("R1 ptrs", {blk_ptr, wr_addr}, 0);
    endtask

    task automatic t_write;
        dec_en = 1'b1; wr_en = 1'b1;
        send(8'h20, -1, 0);
        exp_pt = exp_pt + 16'd2352;
        chk("R2 hdr", hdr_cur, hdr_of(8'h20));
        chk("R2 stat3", stat3, 8'h00);
        chk("R3 pend_n", dec_pend_n, 0);
        chk("R5 blk_ptr", blk_ptr, exp_pt);
        chk("R5 wr_addr", wr_addr, exp_pt);
        chk("R5 adv pulses", adv_cnt, 1);
        chk("R6 write count", wr_cnt, 2052);
        chk("R6 write mismatches", wr_bad, 0);
    endtask

    task automatic t_irq;
        @(negedge clk); dec_irq_en = 1'b1; lvl_en = 1'b1; #1;
        chk("R4 irq both on", irq, 1);
        @(negedge clk); lvl_en = 1'b0; #1;
        chk("R4 irq level off", irq, 0);
        @(negedge clk); lvl_en = 1'b1; dec_irq_en = 1'b0; #1;
        chk("R4 irq enable off", irq, 0);
        @(negedge clk); dec_irq_en = 1'b1;
    endtask

    task automatic t_stat_read;
        @(negedge clk);
        chk("R8 value before read", stat3, 8'h00);
        stat3_rd = 1'b1;
        @(negedge clk);
        stat3_rd = 1'b0;
        chk("R8 stat3 idle", stat3, 8'h80);
        chk("R8 pend cleared", dec_pend_n, 1);
        #1 chk("R4 irq after read", irq, 0);
    endtask

    task automatic t_decode_only;
        dec_en = 1'b1; wr_en = 1'b0;
        send(8'h40, -1, 0);
        chk("R7 hdr", hdr_cur, hdr_of(8'h40));
        chk("R7 stat3/pend", {stat3, dec_pend_n}, {8'h00, 1'b0});
        chk("R7 ptrs", {blk_ptr, wr_addr}, {exp_pt, exp_pt});
        chk("R7 writes", wr_cnt, 0);
        chk("R7 adv", adv_cnt, 0);
        t_stat_read();
    endtask

    task automatic t_mode_hold;
        dec_en = 1'b1; wr_en = 1'b1;
        chk("R10 ready", in_ready, 1);
        send(8'h5A, 100, 500);
        exp_pt = exp_pt + 16'd2352;
        wr_en = 1'b1;
        chk("R10 writes after toggle", wr_cnt, 2052);
        chk("R10 mismatches", wr_bad, 0);
        chk("R10 blk_ptr", blk_ptr, exp_pt);
        chk("R10 hdr", hdr_cur, hdr_of(8'h5A));
    endtask

    task automatic t_wrap;
        logic [15:0] nxt;
        dec_en = 1'b1; wr_en = 1'b1;
        while (int'(14'(exp_pt + 16'd2352)) <= 16384 - 2052) begin
            send(8'h70, -1, 0);
            exp_pt = exp_pt + 16'd2352;
        end
        send(8'hC3, -1, 0);
        exp_pt = exp_pt + 16'd2352;
        chk("R6 wrap write count", wr_cnt, 2052);
        chk("R6 wrap mismatches", wr_bad, 0);
        chk("R5 ptr before rollover", blk_ptr, exp_pt);
        nxt = exp_pt + 16'd2352;
        send(8'h99, -1, 0);
        exp_pt = nxt;
        chk("R5 ptr 16-bit rollover", blk_ptr, exp_pt);
        chk("R5 wa 16-bit rollover", wr_addr, exp_pt);
        chk("R6 after rollover", wr_bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ignored();
        t_write();
        t_irq();
        t_stat_read();
        t_decode_only();
        t_mode_hold();
        t_wrap();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule